// File: doc/BRIEF.md
# SPI Serial Memory Command Interface

This block is the serial front end of a small byte-wide nonvolatile memory. A host talks to it over a four-wire SPI link in mode 0. The host lowers chip select and shifts in an 8-bit opcode, most significant bit first. For array commands a 16-bit address follows, then data bytes. Read data and status bytes come back on the serial output, also MSB first. The SPI pins are brought into the system clock domain through synchronizers. Each serial clock edge is therefore seen as a one-cycle event, and the serial clock may be stopped and restarted at any point.

The memory behind the interface is a behavioural stand-in: a 4096-byte register array, a staging buffer and a busy counter that models the nonvolatile write time. Write data is held in the staging buffer and only goes to the array when chip select rises on a byte boundary. That event clears the write-enable latch and holds the busy flag for a fixed number of cycles. While busy is set, only the status read is served.

The status byte is laid out as follows:
- bit 0: busy
- bit 1: write-enable latch
- bit 6: flag bit
- bits 7:2: the nonvolatile field that a status write replaces

Top module: `spi_mem_cmd_if`

## Requirements
- R1: After reset the serial output enable is low, and a status read returns 0x00.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x00 sets the flag bit (status bit 6). Opcode 0x04 clears both.
- R3: Opcode 0x05 returns the status byte MSB first. Its first bit is valid after the serial clock falls following the eighth rising edge. The live status byte repeats for every further byte clocked while chip select stays low.
- R4: Status reads are served while a write is in progress, and report bit 0 = 1. Bit 0 returns to 0 once BUSY_CYCLES clock cycles have passed since the commit.
- R5: Opcode 0x02 takes a 16-bit address, of which only the low 12 bits are used, followed by data bytes to successive addresses. The data reaches the array only when chip select rises after a whole number of bytes (at least one). A commit clears the write-enable latch.
- R6: If chip select rises in the middle of a data byte, all staged write data is discarded and the array is unchanged.
- R7: Opcode 0x03 takes a 16-bit address (low 12 bits used) and returns successive bytes. Reads and writes both wrap from address 0xFFF to 0x000.
- R8: While busy is set, every opcode except 0x05 is ignored. This includes latch and flag changes, reads (the output enable stays low) and writes.
- R9: An unknown opcode has no effect, and the serial output enable stays low until chip select rises.
- R10: Opcode 0x01 with the latch set takes one data byte. When chip select rises on a byte boundary, status bits 7:2 take that byte's bits 7:2, the latch clears and a busy period starts.
- R11: Write-array and write-status opcodes are ignored when the write-enable latch is clear.
- R12: Holding the serial clock still for any time in the middle of a byte leaves the transfer to resume exactly where it stopped.
- R13: One write command stages at most PAGE_BYTES bytes. Further data bytes in the same command are dropped, and the array locations they name are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the SPI pins are sampled with it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host (mode 0) |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_en | output | 1 | Output enable for the serial data pad |

## Verification
A wrong bit counter or shift register shows up within one byte, as a misaligned read value or a wrongly decoded opcode. A stale decode state shows up as the output enable rising on a command that should stay silent. Faults in the write path stay hidden until chip select rises. They then appear as a busy bit that is missing, a latch that stays set, or a read-back value that is wrong after the busy period. Every such fault is therefore visible at the ports within one command plus one busy period.

// File: rtl/spimem_pkg.sv
// Shared constants and types for the SPI serial memory command interface.
// Assumes 8-bit opcodes and an 8-bit status byte.
package spimem_pkg;

    localparam logic [7:0] OP_SET_WEL  = 8'h06;
    localparam logic [7:0] OP_SET_FLAG = 8'h00;
    localparam logic [7:0] OP_CLR_WEL  = 8'h04;
    localparam logic [7:0] OP_RD_STS   = 8'h05;
    localparam logic [7:0] OP_WR_STS   = 8'h01;
    localparam logic [7:0] OP_RD_ARR   = 8'h03;
    localparam logic [7:0] OP_WR_ARR   = 8'h02;

    // Index of the flag bit inside the 6-bit nonvolatile status field (status bit 6).
    localparam int NV_FLAG_IDX = 4;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_SRD,
        ST_SWR,
        ST_DONE,
        ST_IGNORE
    } ctrl_st_t;

endpackage

// File: rtl/spimem_pin_sync.sv
// Brings the three SPI input pins into the clk domain through STAGES flops
// and turns serial clock and chip select changes into one-cycle events.
// Assumes clk runs at least four times faster than the serial clock.
module spimem_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic si_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_end,
    output logic si_s
);
    // Bit order inside the vectors: [2]=sck, [1]=csn, [0]=si
    localparam logic [2:0] RST_VAL = 3'b010;

    logic [2:0] raw;
    logic [2:0] synced;
    logic       prev_sck;
    logic       prev_csn;

    assign raw = {sck_i, csn_i, si_i};

    for (genvar s = 0; s < 3; s++) begin : g_chain
        logic [STAGES-1:0] chain;
        logic [STAGES-1:0] chain_n;

        // Shift the raw pin into the low end of the chain.
        always_comb begin
            chain_n    = chain << 1;
            chain_n[0] = raw[s];
        end

        // Synchronizer flops for one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[s]}};
            else        chain <= chain_n;
        end

        assign synced[s] = chain[STAGES-1];
    end

    // Remember the previous synced levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sck <= 1'b0;
            prev_csn <= 1'b1;
        end else begin
            prev_sck <= synced[2];
            prev_csn <= synced[1];
        end
    end

    assign sck_rise = synced[2] & ~prev_sck;
    assign sck_fall = ~synced[2] & prev_sck;
    assign cs_act   = ~synced[1];
    assign cs_end   = synced[1] & ~prev_csn;
    assign si_s     = synced[0];

endmodule

// File: rtl/spimem_cmd_ctrl.sv
// Command sequencer: it assembles bytes from the serial input and decodes
// the opcode. It walks the address and data phases and issues strobes to
// the memory model. Output bytes are loaded and shifted on falling serial
// clock edges.
// Assumes edge events come one cycle wide and never on the same cycle.
module spimem_cmd_ctrl
    import spimem_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_act,
    input  logic          cs_end,
    input  logic          si_s,
    input  logic          busy,
    input  logic          wel,
    input  logic [7:0]    status,
    input  logic [7:0]    rd_byte,
    output logic [AW-1:0] rd_addr,
    output logic          stage_we,
    output logic [AW-1:0] stage_addr,
    output logic [7:0]    stage_data,
    output logic          commit,
    output logic          discard,
    output logic          sts_we,
    output logic [5:0]    sts_bits,
    output logic          wel_set,
    output logic          wel_clr,
    output logic          flag_set,
    output logic          flag_clr,
    output logic          so_d,
    output logic          so_en
);
    ctrl_st_t      st;
    ctrl_st_t      st_dec;
    logic [2:0]    bit_cnt;
    logic [7:0]    rx_sh;
    logic [7:0]    rx_next;
    logic [AW-9:0] addr_hi;
    logic          addr_idx;
    logic          is_read;
    logic [AW-1:0] cur_addr;
    logic [7:0]    tx_sh;
    logic          load_pend;
    logic          wr_any;
    logic          sts_got;
    logic [5:0]    sts_q;
    logic          rise;
    logic          fall;
    logic          byte_done;
    logic          opc_ok;

    assign rise      = cs_act & sck_rise;
    assign fall      = cs_act & sck_fall;
    assign rx_next   = {rx_sh[6:0], si_s};
    assign byte_done = rise && (bit_cnt == 3'd7);
    assign opc_ok    = byte_done && (st == ST_OPC) && !busy;

    // Decide the phase that follows a completed opcode byte.
    always_comb begin
        st_dec = ST_IGNORE;
        if (!busy || rx_next == OP_RD_STS) begin
            case (rx_next)
                OP_RD_STS:   st_dec = ST_SRD;
                OP_RD_ARR:   st_dec = ST_ADDR;
                OP_WR_ARR:   st_dec = wel ? ST_ADDR : ST_IGNORE;
                OP_WR_STS:   st_dec = wel ? ST_SWR : ST_IGNORE;
                OP_SET_WEL,
                OP_CLR_WEL,
                OP_SET_FLAG: st_dec = ST_DONE;
                default:     st_dec = ST_IGNORE;
            endcase
        end
    end

    // Strobes toward the memory model.
    always_comb begin
        wel_set    = opc_ok && (rx_next == OP_SET_WEL);
        wel_clr    = opc_ok && (rx_next == OP_CLR_WEL);
        flag_clr   = opc_ok && (rx_next == OP_CLR_WEL);
        flag_set   = opc_ok && (rx_next == OP_SET_FLAG);
        stage_we   = byte_done && (st == ST_WDATA);
        stage_addr = cur_addr;
        stage_data = rx_next;
        commit     = cs_end && (st == ST_WDATA) && (bit_cnt == 3'd0) && wr_any;
        discard    = cs_end && (st == ST_WDATA) && !((bit_cnt == 3'd0) && wr_any);
        sts_we     = cs_end && (st == ST_SWR) && (bit_cnt == 3'd0) && sts_got;
        sts_bits   = sts_q;
    end

    // Sequencer state, input shift and output shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_OPC;
            bit_cnt   <= 3'd0;
            rx_sh     <= 8'd0;
            addr_hi   <= '0;
            addr_idx  <= 1'b0;
            is_read   <= 1'b0;
            cur_addr  <= '0;
            tx_sh     <= 8'd0;
            load_pend <= 1'b0;
            so_en     <= 1'b0;
            wr_any    <= 1'b0;
            sts_got   <= 1'b0;
            sts_q     <= 6'd0;
        end else if (!cs_act) begin
            st        <= ST_OPC;
            bit_cnt   <= 3'd0;
            addr_idx  <= 1'b0;
            load_pend <= 1'b0;
            so_en     <= 1'b0;
            wr_any    <= 1'b0;
            sts_got   <= 1'b0;
        end else begin
            if (rise) begin
                rx_sh   <= rx_next;
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
                case (st)
                    ST_OPC: begin
                        st        <= st_dec;
                        is_read   <= (rx_next == OP_RD_ARR);
                        load_pend <= (st_dec == ST_SRD);
                    end
                    ST_ADDR: begin
                        if (!addr_idx) begin
                            addr_hi  <= rx_next[AW-9:0];
                            addr_idx <= 1'b1;
                        end else begin
                            cur_addr  <= {addr_hi, rx_next};
                            st        <= is_read ? ST_RDATA : ST_WDATA;
                            load_pend <= is_read;
                        end
                    end
                    ST_WDATA: begin
                        cur_addr <= cur_addr + AW'(1);
                        wr_any   <= 1'b1;
                    end
                    ST_RDATA, ST_SRD: load_pend <= 1'b1;
                    ST_SWR: begin
                        sts_q   <= rx_next[7:2];
                        sts_got <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (fall) begin
                if (load_pend) begin
                    tx_sh     <= (st == ST_SRD) ? status : rd_byte;
                    load_pend <= 1'b0;
                    so_en     <= 1'b1;
                    if (st == ST_RDATA) cur_addr <= cur_addr + AW'(1);
                end else begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign rd_addr = cur_addr;
    assign so_d    = tx_sh[7];

    AST_CS_END_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_en); // R9
    AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> (st == ST_RDATA || st == ST_SRD)); // R9
    AST_BITCNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sck_rise) |=> $stable(bit_cnt)); // R12
    AST_ONE_END_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({commit, discard, sts_we}) <= 1); // R6

endmodule

// File: rtl/spimem_core_model.sv
// Stand-in for the nonvolatile core. It holds a byte array, a staging
// buffer, the status bits and a busy counter. A commit drains the staging
// buffer into the array, one byte per cycle, during the busy period.
// Assumes PAGE >= 2 and BUSY_CYCLES >= PAGE.
module spimem_core_model
    import spimem_pkg::*;
#(
    parameter int AW          = 12,
    parameter int PAGE        = 16,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    input  logic          stage_we,
    input  logic [AW-1:0] stage_addr,
    input  logic [7:0]    stage_data,
    input  logic          commit,
    input  logic          discard,
    input  logic          sts_we,
    input  logic [5:0]    sts_bits,
    input  logic          wel_set,
    input  logic          wel_clr,
    input  logic          flag_set,
    input  logic          flag_clr,
    output logic [7:0]    status,
    output logic          busy,
    output logic          wel
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = $clog2(PAGE + 1);
    localparam int IW    = $clog2(PAGE);
    localparam int CW    = $clog2(BUSY_CYCLES + 1);

    logic [7:0]    mem   [DEPTH];
    logic [AW-1:0] stg_a [PAGE];
    logic [7:0]    stg_d [PAGE];
    logic [PW-1:0] stg_cnt;
    logic [PW-1:0] drain_n;
    logic [PW-1:0] drain_i;
    logic [CW-1:0] bcnt;
    logic [5:0]    nv;
    logic          drain_go;

    assign drain_go = busy && (drain_i < drain_n);

    // Staging buffer entries; bytes beyond PAGE are dropped.
    always_ff @(posedge clk) begin
        if (stage_we && stg_cnt < PW'(PAGE)) begin
            stg_a[stg_cnt[IW-1:0]] <= stage_addr;
            stg_d[stg_cnt[IW-1:0]] <= stage_data;
        end
    end

    // Array storage, written only while draining a committed buffer.
    always_ff @(posedge clk) begin
        if (drain_go) mem[stg_a[drain_i[IW-1:0]]] <= stg_d[drain_i[IW-1:0]];
    end

    // Staging count, busy timer and drain pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_cnt <= '0;
            drain_n <= '0;
            drain_i <= '0;
            bcnt    <= '0;
            busy    <= 1'b0;
        end else if (commit || sts_we) begin
            busy    <= 1'b1;
            bcnt    <= CW'(BUSY_CYCLES - 1);
            drain_n <= commit ? stg_cnt : '0;
            drain_i <= '0;
            stg_cnt <= '0;
        end else begin
            if (discard) stg_cnt <= '0;
            else if (stage_we && stg_cnt < PW'(PAGE)) stg_cnt <= stg_cnt + PW'(1);
            if (busy) begin
                if (bcnt == '0) busy <= 1'b0;
                else            bcnt <= bcnt - CW'(1);
            end
            if (drain_go) drain_i <= drain_i + PW'(1);
        end
    end

    // Write-enable latch and nonvolatile status field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
            nv  <= 6'd0;
        end else begin
            if (commit || sts_we || wel_clr) wel <= 1'b0;
            else if (wel_set)                wel <= 1'b1;
            if (sts_we)        nv              <= sts_bits;
            else if (flag_set) nv[NV_FLAG_IDX] <= 1'b1;
            else if (flag_clr) nv[NV_FLAG_IDX] <= 1'b0;
        end
    end

    assign rd_byte = mem[rd_addr];
    assign status  = {nv, wel, busy};

    AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stg_cnt <= PW'(PAGE)); // R13
    AST_COMMIT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || sts_we) |=> busy); // R4
    AST_COMMIT_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || sts_we) |=> !wel); // R5
    AST_NO_STAGE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stage_we); // R8

endmodule

// File: rtl/spi_mem_cmd_if.sv
// Top of the SPI serial memory command interface. It joins the pin
// synchronizer, the command sequencer and the memory model.
// Assumes the host serial clock is slower than clk/4 and 9 <= ADDR_BITS <= 16.
module spi_mem_cmd_if #(
    parameter int ADDR_BITS   = 12,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_en
);
    logic                 sck_rise, sck_fall, cs_act, cs_end, si_s;
    logic                 busy, wel;
    logic [7:0]           status, rd_byte, stage_data;
    logic [ADDR_BITS-1:0] rd_addr, stage_addr;
    logic                 stage_we, commit, discard, sts_we;
    logic [5:0]           sts_bits;
    logic                 wel_set, wel_clr, flag_set, flag_clr;

    spimem_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (spi_sck),
        .csn_i    (spi_csn),
        .si_i     (spi_si),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_end   (cs_end),
        .si_s     (si_s)
    );

    spimem_cmd_ctrl #(.AW(ADDR_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .cs_act     (cs_act),
        .cs_end     (cs_end),
        .si_s       (si_s),
        .busy       (busy),
        .wel        (wel),
        .status     (status),
        .rd_byte    (rd_byte),
        .rd_addr    (rd_addr),
        .stage_we   (stage_we),
        .stage_addr (stage_addr),
        .stage_data (stage_data),
        .commit     (commit),
        .discard    (discard),
        .sts_we     (sts_we),
        .sts_bits   (sts_bits),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .flag_set   (flag_set),
        .flag_clr   (flag_clr),
        .so_d       (spi_so),
        .so_en      (spi_so_en)
    );

    spimem_core_model #(
        .AW          (ADDR_BITS),
        .PAGE        (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rd_byte    (rd_byte),
        .stage_we   (stage_we),
        .stage_addr (stage_addr),
        .stage_data (stage_data),
        .commit     (commit),
        .discard    (discard),
        .sts_we     (sts_we),
        .sts_bits   (sts_bits),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .flag_set   (flag_set),
        .flag_clr   (flag_clr),
        .status     (status),
        .busy       (busy),
        .wel        (wel)
    );

endmodule

// File: tb/spi_mem_cmd_if_tb.sv
// Self-checking bench: drives SPI mode 0 transactions and compares read-back
// bytes and status bytes against values derived from the requirements.
module spi_mem_cmd_if_tb;
    localparam int H    = 6;     // clk cycles per serial clock half period
    localparam int BUSY = 1000;
    localparam int NV   = 6;
    // Vector = {host address, data byte}
    localparam logic [23:0] VEC [NV] = '{
        {16'h0010, 8'h11}, {16'h0123, 8'hC3}, {16'hF456, 8'h9E},
        {16'h0800, 8'h00}, {16'h07FF, 8'hFF}, {16'h1ABC, 8'h3C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
    logic spi_so, spi_so_en;
    logic [7:0] tb_tx [32];
    logic [7:0] tb_rx [32];
    logic       oe_seen;
    logic [7:0] s;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_mem_cmd_if u_dut (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_si(spi_si), .spi_so(spi_so), .spi_so_en(spi_so_en)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic spi_txn(input int n, input int extra, input int pause_at);
        oe_seen = 1'b0;
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (H) @(negedge clk);
        for (int k = 0; k < n * 8 + extra; k++) begin
            automatic int b = k / 8;
            automatic int i = 7 - (k % 8);
            spi_si = (b < n) ? tb_tx[b][i] : 1'b1;
            repeat (H) @(negedge clk);
            if (b < 32) tb_rx[b][i] = spi_so;
            if (spi_so_en) oe_seen = 1'b1;
            spi_sck = 1'b1;
            repeat (H) @(negedge clk);
            if (k == pause_at) repeat (200) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        if (spi_so_en) oe_seen = 1'b1;
        spi_csn = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        tb_tx[0] = op;
        spi_txn(1, 0, -1);
    endtask

    task automatic get_sts(output logic [7:0] v);
        tb_tx[0] = 8'h05;
        tb_tx[1] = 8'h00;
        spi_txn(2, 0, -1);
        v = tb_rx[1];
    endtask

    // Data bytes must already be in tb_tx[3..].
    task automatic wr_arr(input logic [15:0] a, input int n, input int extra, input int pause_at);
        tb_tx[0] = 8'h02;
        tb_tx[1] = a[15:8];
        tb_tx[2] = a[7:0];
        spi_txn(3 + n, extra, pause_at);
    endtask

    task automatic rd_arr(input logic [15:0] a, input int n, input int pause_at);
        tb_tx[0] = 8'h03;
        tb_tx[1] = a[15:8];
        tb_tx[2] = a[7:0];
        for (int i = 0; i < n; i++) tb_tx[3 + i] = 8'h00;
        spi_txn(3 + n, 0, pause_at);
    endtask

    task automatic settle();
        repeat (BUSY + 100) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1 so_en after reset", {15'd0, spi_so_en}, 16'd0);
        get_sts(s);
        chk("R1 status after reset", {8'd0, s}, 16'h00);

        // R2: latch and flag opcodes
        cmd1(8'h06); get_sts(s); chk("R2 set latch", {8'd0, s}, 16'h02);
        cmd1(8'h04); get_sts(s); chk("R2 clear latch", {8'd0, s}, 16'h00);
        cmd1(8'h00); get_sts(s); chk("R2 set flag", {8'd0, s}, 16'h40);
        cmd1(8'h04); get_sts(s); chk("R2 clear flag", {8'd0, s}, 16'h00);

        // R3: status repeats every byte
        cmd1(8'h06);
        tb_tx[0] = 8'h05; tb_tx[1] = 8'h00; tb_tx[2] = 8'h00;
        spi_txn(3, 0, -1);
        chk("R3 first status byte", {8'd0, tb_rx[1]}, 16'h02);
        chk("R3 repeated status byte", {8'd0, tb_rx[2]}, 16'h02);
        cmd1(8'h04);

        // R5: table of single-byte writes read back through masked addresses
        for (int v = 0; v < NV; v++) begin
            cmd1(8'h06);
            tb_tx[3] = VEC[v][7:0];
            wr_arr(VEC[v][23:8], 1, 0, -1);
            settle();
            rd_arr(VEC[v][23:8] & 16'h0FFF, 1, -1);
            chk("R5 table read-back", {8'd0, tb_rx[3]}, {8'd0, VEC[v][7:0]});
        end

        // R4 and R8: behaviour while busy
        cmd1(8'h06);
        tb_tx[3] = 8'h5C;
        wr_arr(16'h0030, 1, 0, -1);
        get_sts(s);
        chk("R4 busy bit during write", {8'd0, s}, 16'h01);
        cmd1(8'h06);
        get_sts(s);
        chk("R8 latch opcode ignored while busy", {8'd0, s}, 16'h01);
        rd_arr(16'h0030, 1, -1);
        chk("R8 read ignored while busy", {15'd0, oe_seen}, 16'd0);
        settle();
        get_sts(s);
        chk("R4 busy clears", {8'd0, s}, 16'h00);
        rd_arr(16'h0030, 1, -1);
        chk("R5 value after busy", {8'd0, tb_rx[3]}, 16'h5C);

        // R6: chip select rises mid-byte, so the write is discarded
        cmd1(8'h06);
        tb_tx[3] = 8'h77; wr_arr(16'h0020, 1, 0, -1); settle();
        cmd1(8'h06);
        tb_tx[3] = 8'h99; wr_arr(16'h0020, 1, 3, -1); settle();
        rd_arr(16'h0020, 1, -1);
        chk("R6 partial byte discarded", {8'd0, tb_rx[3]}, 16'h77);

        // R11: write with the latch clear is ignored
        cmd1(8'h04);
        tb_tx[3] = 8'h33; wr_arr(16'h0020, 1, 0, -1); settle();
        rd_arr(16'h0020, 1, -1);
        chk("R11 write without latch", {8'd0, tb_rx[3]}, 16'h77);

        // R7: wrap at the end of the array
        cmd1(8'h06);
        tb_tx[3] = 8'hA6; tb_tx[4] = 8'hB7;
        wr_arr(16'h0FFF, 2, 0, -1); settle();
        rd_arr(16'h0FFF, 2, -1);
        chk("R7 last byte", {8'd0, tb_rx[3]}, 16'hA6);
        chk("R7 wrapped byte", {8'd0, tb_rx[4]}, 16'hB7);

        // R13: bytes beyond the page are dropped
        cmd1(8'h06);
        tb_tx[3] = 8'hAA; tb_tx[4] = 8'hBB;
        wr_arr(16'h0110, 2, 0, -1); settle();
        cmd1(8'h06);
        for (int i = 0; i < 18; i++) tb_tx[3 + i] = 8'h40 + 8'(i);
        wr_arr(16'h0100, 18, 0, -1); settle();
        rd_arr(16'h0100, 18, -1);
        chk("R13 first staged byte", {8'd0, tb_rx[3]}, 16'h40);
        chk("R13 last staged byte", {8'd0, tb_rx[18]}, 16'h4F);
        chk("R13 dropped byte 17", {8'd0, tb_rx[19]}, 16'hAA);
        chk("R13 dropped byte 18", {8'd0, tb_rx[20]}, 16'hBB);

        // R9: unknown opcode
        tb_tx[0] = 8'hA7; tb_tx[1] = 8'h00;
        spi_txn(2, 0, -1);
        chk("R9 output enable stays low", {15'd0, oe_seen}, 16'd0);
        get_sts(s);
        chk("R9 status unchanged", {8'd0, s}, 16'h00);

        // R10: status write
        cmd1(8'h06);
        tb_tx[0] = 8'h01; tb_tx[1] = 8'hFF;
        spi_txn(2, 0, -1);
        get_sts(s);
        chk("R10 busy after status write", {8'd0, s[0]}, 16'h01);
        settle();
        get_sts(s);
        chk("R10 status field written", {8'd0, s}, 16'hFC);
        cmd1(8'h04); get_sts(s); chk("R10 flag clear keeps others", {8'd0, s}, 16'hBC);
        cmd1(8'h00); get_sts(s); chk("R10 flag set again", {8'd0, s}, 16'hFC);
        cmd1(8'h01 & 8'h00 | 8'h06);
        tb_tx[0] = 8'h01; tb_tx[1] = 8'h00;
        spi_txn(2, 0, -1); settle();
        get_sts(s);
        chk("R10 status field restored", {8'd0, s}, 16'h00);

        // R12: clock stopped mid-byte during write and read
        cmd1(8'h06);
        tb_tx[3] = 8'h6D;
        wr_arr(16'h0040, 1, 0, 27); settle();
        rd_arr(16'h0040, 1, 28);
        chk("R12 paused transfer", {8'd0, tb_rx[3]}, 16'h6D);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule